// File: doc/BRIEF.md
# Scan Test Protocol Sequencer

This block drives one scan chain through a fixed per-pattern protocol. Every pattern passes through four phases in a fixed order. First comes a shift phase that lasts one cycle per chain cell, with scan-enable high. Then come three single-cycle phases with scan-enable low: a measure cycle, a capture cycle and a scan-out strobe cycle. The block produces scan-enable, a gated test clock, the serial scan-in stream and a compare qualifier. The qualifier consists of a valid flag, a don't-care mask and the expected bit. It also folds every unmasked compare into a sticky fail flag.

Software or a tester front end writes a stimulus word and its expected response word through a load port while the sequencer is idle, then pulses start. The test clock pulses at the end of each shift cycle and at the end of the capture cycle. The last cell's captured bit is therefore compared in the strobe cycle, before any further shift disturbs it. The remaining captured bits stream out during the next pattern's shift. They are compared against the expected word of the pattern that produced them. The first cell appears only in the final shift cycle, and that compare is masked. After a parameterised number of patterns the sequence is complete and further starts are ignored until reset.

Top module: `scan_proto_seq`

## Requirements
- R1: After start_i is sampled in idle, scan_en_o is high for exactly CHAIN_LEN consecutive cycles. Three cycles with scan_en_o low follow (measure, capture, strobe), then the block returns to idle.
- R2: tck_o pulses once at the end of every shift cycle and once at the end of the capture cycle. It stays low in idle, measure and strobe cycles. Its enable changes only while clk_i is low.
- R3: In shift cycle c (counting from 0), scan_in_o carries bit CHAIN_LEN-1-c of the loaded stimulus word. After the shift, stimulus bit j sits in cell j, where cell 0 is at the scan-in end. scan_in_o is 0 when not shifting.
- R4: The strobe cycle is the only cycle with done_o high. In it, cmp_valid_o=1, cmp_mask_o=0 and cmp_exp_o equals bit CHAIN_LEN-1 of the current expected word.
- R5: In shift cycle c with c<CHAIN_LEN-1, cmp_valid_o=1 and cmp_exp_o equals bit CHAIN_LEN-1-c of the previous pattern's expected word, unmasked. In the first pattern after reset, every shift compare is masked.
- R6: In the final shift cycle, cmp_valid_o=1 and cmp_mask_o=1, so no mismatch there can raise fail_o.
- R7: fail_o rises on the edge that ends a cycle where cmp_valid_o=1, cmp_mask_o=0 and scan_out_i differs from cmp_exp_o. It stays high until reset.
- R8: After NUM_PAT patterns, seq_done_o goes high. From then on, start_i produces no shift, no clock pulse and no done_o.
- R9: During and after reset the block is idle, with scan_en_o, tck_o, scan_in_o, cmp_valid_o, done_o, fail_o and seq_done_o all 0.
- R10: load_i takes effect only in idle. A load during a pattern changes neither the bits being shifted nor the expected bits compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one pattern (sampled in idle) |
| load_i | input | 1 | Write stimulus and expected words |
| load_pat_i | input | CHAIN_LEN | Stimulus word, bit j lands in cell j |
| load_exp_i | input | CHAIN_LEN | Expected response word, bit j for cell j |
| scan_out_i | input | 1 | Serial output of the last chain cell |
| scan_en_o | output | 1 | Shift select for the chain |
| tck_o | output | 1 | Gated test clock |
| scan_in_o | output | 1 | Serial data into cell 0 |
| cmp_valid_o | output | 1 | A compare is scheduled this cycle |
| cmp_mask_o | output | 1 | Compare is don't-care |
| cmp_exp_o | output | 1 | Expected scan_out_i value |
| fail_o | output | 1 | Sticky mismatch flag |
| done_o | output | 1 | Strobe cycle, pattern completes |
| seq_done_o | output | 1 | All NUM_PAT patterns applied |

## Verification
The bench models the chain on tck_o and runs all sixteen stimulus words of a four-cell chain. It checks the phase order, the pulse counts and the cell placement. A design that pulsed in measure or strobe, or shifted bits in reverse, would leave the chain holding the wrong word at capture. Faulty expected words hit three cases. A wrong bit 0 must stay hidden by the last-shift mask. A wrong upper bit must fail only during the following pattern, not the first. A wrong top bit must fail at the strobe. A load issued mid-shift and a start issued after the final pattern probe the two ignore rules.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SHIFT,
    PH_MEAS,
    PH_CAPT,
    PH_STRB
  } phase_e;
endpackage

// File: rtl/scan_phase_fsm.sv
module scan_phase_fsm
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int NUM_PAT   = 16,
  localparam int CW = $clog2(CHAIN_LEN),
  localparam int PW = $clog2(NUM_PAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output phase_e        phase_o,
  output logic [CW-1:0] idx_o,
  output logic          first_o,
  output logic          seq_done_o
);
  localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);
  localparam logic [PW-1:0] FINAL = PW'(NUM_PAT - 1);

  phase_e        phase_q;
  logic [CW-1:0] idx_q;
  logic [PW-1:0] pat_q;
  logic          fin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      pat_q   <= '0;
      fin_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i && !fin_q) begin
          phase_q <= PH_SHIFT;
          idx_q   <= '0;
        end
        PH_SHIFT: begin
          if (idx_q == LAST) phase_q <= PH_MEAS;
          else idx_q <= idx_q + 1'b1;
        end
        PH_MEAS: phase_q <= PH_CAPT;
        PH_CAPT: phase_q <= PH_STRB;
        PH_STRB: begin
          phase_q <= PH_IDLE;
          pat_q   <= pat_q + 1'b1;
          if (pat_q == FINAL) fin_q <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign idx_o      = idx_q;
  assign first_o    = (pat_q == '0);
  assign seq_done_o = fin_q;
endmodule

// File: rtl/scan_clk_gate.sv
module scan_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_en_i,
  output logic tck_o
);
  logic gate_q;

  // enable settles while clk is low; pulse lands on the edge closing the cycle
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= pulse_en_i;
  end

  assign tck_o = clk_i & gate_q;
endmodule

// File: rtl/scan_data_path.sv
module scan_data_path
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  localparam int CW = $clog2(CHAIN_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [CHAIN_LEN-1:0] load_pat_i,
  input  logic [CHAIN_LEN-1:0] load_exp_i,
  input  phase_e               phase_i,
  input  logic [CW-1:0]        idx_i,
  input  logic                 first_i,
  input  logic                 scan_out_i,
  output logic                 scan_in_o,
  output logic                 cmp_valid_o,
  output logic                 cmp_mask_o,
  output logic                 cmp_exp_o,
  output logic                 fail_o
);
  localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);

  logic [CHAIN_LEN-1:0] pat_q, exp_q, prev_q;
  logic                 fail_q;
  logic [CW-1:0]        sel;

  assign sel = LAST - idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q  <= '0;
      exp_q  <= '0;
      prev_q <= '0;
    end else begin
      if (load_i && phase_i == PH_IDLE) begin
        pat_q <= load_pat_i;
        exp_q <= load_exp_i;
      end
      // response of this pattern drains during the next shift
      if (phase_i == PH_STRB) prev_q <= exp_q;
    end
  end

  always_comb begin
    scan_in_o   = 1'b0;
    cmp_valid_o = 1'b0;
    cmp_mask_o  = 1'b0;
    cmp_exp_o   = 1'b0;
    if (phase_i == PH_SHIFT) begin
      scan_in_o   = pat_q[sel];
      cmp_valid_o = 1'b1;
      cmp_mask_o  = first_i || (idx_i == LAST);
      cmp_exp_o   = cmp_mask_o ? 1'b0 : prev_q[sel];
    end else if (phase_i == PH_STRB) begin
      cmp_valid_o = 1'b1;
      cmp_exp_o   = exp_q[CHAIN_LEN-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fail_q <= 1'b0;
    else if (cmp_valid_o && !cmp_mask_o && (scan_out_i != cmp_exp_o)) fail_q <= 1'b1;
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/scan_proto_seq.sv
module scan_proto_seq
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int NUM_PAT   = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 load_i,
  input  logic [CHAIN_LEN-1:0] load_pat_i,
  input  logic [CHAIN_LEN-1:0] load_exp_i,
  input  logic                 scan_out_i,
  output logic                 scan_en_o,
  output logic                 tck_o,
  output logic                 scan_in_o,
  output logic                 cmp_valid_o,
  output logic                 cmp_mask_o,
  output logic                 cmp_exp_o,
  output logic                 fail_o,
  output logic                 done_o,
  output logic                 seq_done_o
);
  localparam int CW = $clog2(CHAIN_LEN);

  phase_e        phase;
  logic [CW-1:0] idx;
  logic          first;

  scan_phase_fsm #(.CHAIN_LEN(CHAIN_LEN), .NUM_PAT(NUM_PAT)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .phase_o    (phase),
    .idx_o      (idx),
    .first_o    (first),
    .seq_done_o (seq_done_o)
  );

  scan_clk_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pulse_en_i (phase == PH_SHIFT || phase == PH_CAPT),
    .tck_o      (tck_o)
  );

  scan_data_path #(.CHAIN_LEN(CHAIN_LEN)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_pat_i  (load_pat_i),
    .load_exp_i  (load_exp_i),
    .phase_i     (phase),
    .idx_i       (idx),
    .first_i     (first),
    .scan_out_i  (scan_out_i),
    .scan_in_o   (scan_in_o),
    .cmp_valid_o (cmp_valid_o),
    .cmp_mask_o  (cmp_mask_o),
    .cmp_exp_o   (cmp_exp_o),
    .fail_o      (fail_o)
  );

  assign scan_en_o = (phase == PH_SHIFT);
  assign done_o    = (phase == PH_STRB);
endmodule

// File: rtl/scan_proto_seq_chk.sv
module scan_proto_seq_chk #(
  parameter int CHAIN_LEN = 8,
  localparam int RW = $clog2(CHAIN_LEN + 1)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scan_out_i,
  input logic scan_en_o,
  input logic scan_in_o,
  input logic cmp_valid_o,
  input logic cmp_mask_o,
  input logic cmp_exp_o,
  input logic fail_o,
  input logic done_o,
  input logic seq_done_o
);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (scan_en_o) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  p_shift_cap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o |-> run_q < RW'(CHAIN_LEN));
  p_shift_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scan_en_o) |-> run_q == RW'(CHAIN_LEN));
  p_meas_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scan_en_o) |-> !done_o && !cmp_valid_o);
  p_in_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_o |-> !scan_in_o);
  p_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !scan_en_o && cmp_valid_o && !cmp_mask_o);
  p_done_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_shift_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o |-> cmp_valid_o);
  p_last_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scan_en_o) |-> $past(cmp_mask_o));
  p_fail_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_o && !cmp_mask_o && scan_out_i != cmp_exp_o) |=> fail_o);
  p_fail_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o);
  p_fin_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> !scan_en_o && !done_o);
endmodule

bind scan_proto_seq scan_proto_seq_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scan_out_i  (scan_out_i),
  .scan_en_o   (scan_en_o),
  .scan_in_o   (scan_in_o),
  .cmp_valid_o (cmp_valid_o),
  .cmp_mask_o  (cmp_mask_o),
  .cmp_exp_o   (cmp_exp_o),
  .fail_o      (fail_o),
  .done_o      (done_o),
  .seq_done_o  (seq_done_o)
);

// File: tb/scan_proto_seq_test.sv
module scan_proto_seq_test;
  localparam int N  = 4;
  localparam int NP = 4;
  localparam logic [N-1:0] KEY = 4'b0110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, load = 1'b0;
  logic [N-1:0] lpat = '0, lexp = '0;
  logic scan_en, tck, scan_in, cvalid, cmask, cexp, fail, done, sdone;

  logic [N-1:0] chain = '0, cap_seen = '0;
  logic en_s = 1'b0, in_s = 1'b0;
  int sh_pulses = 0, cap_pulses = 0;
  int checks = 0, errors = 0;

  logic [N-1:0] prev_e, prev_r;
  bit exp_fail;
  int pidx;

  always #4 clk = ~clk;

  scan_proto_seq #(.CHAIN_LEN(N), .NUM_PAT(NP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .load_i(load),
    .load_pat_i(lpat), .load_exp_i(lexp), .scan_out_i(chain[N-1]),
    .scan_en_o(scan_en), .tck_o(tck), .scan_in_o(scan_in),
    .cmp_valid_o(cvalid), .cmp_mask_o(cmask), .cmp_exp_o(cexp),
    .fail_o(fail), .done_o(done), .seq_done_o(sdone)
  );

  // chain model: cell 0 at scan-in end, capture inverts KEY bits
  always @(negedge clk) begin
    en_s <= scan_en;
    in_s <= scan_in;
  end
  always @(posedge tck) begin
    if (en_s) begin
      chain <= {chain[N-2:0], in_s};
      sh_pulses <= sh_pulses + 1;
    end else begin
      cap_seen <= chain;
      chain <= chain ^ KEY;
      cap_pulses <= cap_pulses + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    pidx = 0; exp_fail = 0; prev_e = '0; prev_r = '0;
    @(negedge clk);
  endtask

  task automatic run_pat(input logic [N-1:0] p, input logic [N-1:0] e, input bit jam);
    int s0, c0;
    bit first;
    logic [N-1:0] r;
    first = (pidx == 0);
    r = p ^ KEY;
    @(negedge clk); load = 1'b1; lpat = p; lexp = e;
    @(negedge clk); load = 1'b0; start = 1'b1;
    s0 = sh_pulses; c0 = cap_pulses;
    for (int cyc = 0; cyc < N + 3; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (jam && cyc == 1) begin load = 1'b1; lpat = ~p; lexp = ~e; end
      if (jam && cyc == 2) load = 1'b0;
      chk(scan_en == (cyc < N), "R1 scan_en", scan_en, cyc < N);
      chk(done == (cyc == N + 2), "R4 done", done, cyc == N + 2);
      chk(cvalid == (cyc < N || cyc == N + 2), "R5 cmp_valid", cvalid, cyc < N || cyc == N + 2);
      if (cyc < N) chk(scan_in == p[N-1-cyc], "R3 R10 scan_in", scan_in, p[N-1-cyc]);
      else         chk(scan_in == 1'b0, "R3 scan_in quiet", scan_in, 0);
      if (cyc == N - 1) chk(cmask == 1'b1, "R6 last shift mask", cmask, 1);
      else if (cyc < N - 1) begin
        chk(cmask == first, "R5 shift mask", cmask, first);
        if (!first) chk(cexp == prev_e[N-1-cyc], "R5 shift exp", cexp, prev_e[N-1-cyc]);
      end else if (cyc == N + 2) begin
        chk(cmask == 1'b0, "R4 strobe mask", cmask, 0);
        chk(cexp == e[N-1], "R4 R10 strobe exp", cexp, e[N-1]);
      end
    end
    if (!first && (((prev_r ^ prev_e) & {{(N-1){1'b1}}, 1'b0}) != '0)) exp_fail = 1;
    if (r[N-1] != e[N-1]) exp_fail = 1;
    @(negedge clk);
    chk(sh_pulses - s0 == N, "R2 shift pulses", sh_pulses - s0, N);
    chk(cap_pulses - c0 == 1, "R2 capture pulses", cap_pulses - c0, 1);
    chk(cap_seen == p, "R3 chain at capture", cap_seen, p);
    chk(fail == exp_fail, "R7 fail", fail, exp_fail);
    chk(!scan_en && !done, "R1 back to idle", scan_en, 0);
    prev_e = e; prev_r = r; pidx++;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0, c0;
    @(negedge clk);
    chk(!scan_en && !scan_in && !cvalid, "R9 reset outputs", scan_en, 0);
    chk(!done && !fail && !sdone, "R9 reset flags", fail, 0);
    @(posedge clk); #1;
    chk(tck == 1'b0, "R9 tck gated in reset", tck, 0);
    do_reset();
    s0 = sh_pulses + cap_pulses;
    repeat (3) @(negedge clk);
    chk(sh_pulses + cap_pulses == s0, "R2 idle no pulse", sh_pulses + cap_pulses - s0, 0);

    // all 16 stimulus words, four per reset
    for (int b = 0; b < 4; b++) begin
      if (b > 0) do_reset();
      for (int k = 0; k < NP; k++) begin
        logic [N-1:0] p;
        p = N'(b * 4 + k);
        run_pat(p, p ^ KEY, (b == 0 && k == 1));
        chk(sdone == (k == NP - 1), "R8 seq_done", sdone, k == NP - 1);
      end
    end
    // start after completion is ignored
    s0 = sh_pulses; c0 = cap_pulses;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < N + 4; i++) begin
      @(negedge clk);
      chk(!scan_en && !done, "R8 start ignored", scan_en | done, 0);
    end
    chk(sh_pulses == s0 && cap_pulses == c0, "R8 no pulses", sh_pulses - s0, 0);

    // bit 0 wrong: masked; top bit wrong: strobe fail
    do_reset();
    run_pat(4'h3, 4'h3 ^ KEY, 0);
    run_pat(4'h9, (4'h9 ^ KEY) ^ 4'b0001, 0);
    run_pat(4'hC, 4'hC ^ KEY, 0);
    chk(fail == 1'b0, "R6 masked bit no fail", fail, 0);
    run_pat(4'h5, (4'h5 ^ KEY) ^ 4'b1000, 0);

    // bit 1 wrong in first pattern: fails only during next shift
    do_reset();
    run_pat(4'hA, (4'hA ^ KEY) ^ 4'b0010, 0);
    chk(fail == 1'b0, "R5 first pattern no fail", fail, 0);
    run_pat(4'h6, 4'h6 ^ KEY, 0);
    run_pat(4'h1, 4'h1 ^ KEY, 0);
    chk(fail == 1'b1, "R7 fail sticky", fail, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule